// File: doc/BRIEF.md
# Seconds Counter With Alarm Match

This block is a memory-mapped real-time clock core. A 32-bit unsigned count of seconds moves forward once per second. A tick divider produces that second from the core clock, and the number of core cycles in one second is a parameter. Software sets the time by writing a load value. That value replaces the count at the next one-second update, not at once, so software sees the new time one update after the write. A match register holds the alarm time. When an update gives a count equal to the match value, the event is latched into a raw status bit.

The alarm has two gates, an enable bit and a mask bit. Software can read the raw status and the gated (masked) status. The single level interrupt output follows the gated status. Reading a dedicated acknowledge word clears the latched event. Writing only the run bit starts the clock with the alarm interrupt off. A control bit selects what happens at the top of the range: the count either rolls over to zero or stays at the largest value.

The register bus is a plain single-cycle 32-bit interface. It has a byte address, and only the word index is decoded. Read data is combinational, and a write takes effect at the clock edge where it is sampled.

Top module: `rtc_sec_core`

## Requirements
- R1: After synchronous reset, the count, match, load and control words read 0, both status words read 0, and `irq_o` is low.
- R2: Word index = `bus_addr[4:2]`. Byte offsets: 0x00 count (read-only), 0x04 match, 0x08 load, 0x0C control, 0x10 gated status, 0x14 raw status, 0x18 acknowledge, 0x1C version (read-only, returns the `VERSION` parameter). Match and load read back the last value written. Control reads back bits 3:0 and reads zero above them. Writes to offsets 0x00, 0x10, 0x14, 0x18 and 0x1C change nothing.
- R3: Control bit 2 (run) enables counting. The first update comes exactly `TICKS_PER_SEC` cycles after the edge that sets run. Later updates come every `TICKS_PER_SEC` cycles, and each one adds one to the count.
- R4: A write to the load word does not change the count at once. At the next update, the load value replaces the increment.
- R5: While run is 0, the count holds, and the divider restarts from zero. A load written while stopped is applied at the first update after run is set.
- R6: The raw alarm bit (bit 0 of offsets 0x10/0x14) is set at an update whose resulting count equals the match word.
- R7: Control bit 0 is alarm enable and bit 1 is alarm mask. Gated status bit 0 = raw AND enable AND NOT mask, and `irq_o` equals gated status.
- R8: A read of offset 0x18 clears the raw alarm bit. If a new alarm event occurs in the same cycle, the set wins.
- R9: Control bit 3 selects the behaviour at 2^32-1. When it is 1, the next update gives 0. When it is 0, the count stays at 2^32-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, word index in bits 4:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Level alarm interrupt (gated status) |

## Verification
The bound checker tracks the count at every cycle. It checks the single-step increment, the replacement by a pending load, the hold while stopped, and both top-of-range behaviours. It also checks that a rising raw bit coincides with count equal to match, that an acknowledge without an update clears the raw bit, and that the mask or a clear raw bit keeps the interrupt low. Some properties only the bench scenarios can show. These are the exact cycle on which the first update lands after the run bit is set, and a load value that stays invisible until that update. They also include the read-back and ignored-write behaviour of each offset, and a whole alarm/acknowledge round trip through the bus.

// File: rtl/rtc_sec_pkg.sv
`timescale 1ns/100ps
package rtc_sec_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    // word index decoded from bus_addr[4:2]
    typedef enum logic [2:0] {
        REG_COUNT = 3'd0,
        REG_MATCH = 3'd1,
        REG_LOAD  = 3'd2,
        REG_CTRL  = 3'd3,
        REG_MSTAT = 3'd4,
        REG_RSTAT = 3'd5,
        REG_ACK   = 3'd6,
        REG_VER   = 3'd7
    } reg_sel_e;

    // control word, bit 3 down to bit 0
    typedef struct packed {
        logic wrap;
        logic run;
        logic mask;
        logic ie;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        return ctrl_t'(w[CTRL_W-1:0]);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        return {{(DATA_W-CTRL_W){1'b0}}, c};
    endfunction

    function automatic logic irq_gate(input logic raw, input ctrl_t c);
        return raw & c.ie & ~c.mask;
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
`timescale 1ns/100ps
module rtc_tick_div #(
    parameter int unsigned TICKS_PER_SEC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

    generate
        if (TICKS_PER_SEC <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_div
            localparam logic [DIV_W-1:0] LAST = DIV_W'(TICKS_PER_SEC - 1);
            logic [DIV_W-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    phase <= '0;
                end else if (phase == LAST) begin
                    phase <= '0;
                end else begin
                    phase <= phase + DIV_W'(1);
                end
            end

            assign tick = run && (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/rtc_sec_counter.sv
`timescale 1ns/100ps
module rtc_sec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wrap_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             load_pending,
    output logic             alarm_hit
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        if (load_pending) begin
            next_cnt = load_val;
        end else if (count == TOP) begin
            next_cnt = wrap_en ? '0 : TOP;
        end else begin
            next_cnt = count + CNT_W'(1);
        end
    end

    assign alarm_hit = tick && (next_cnt == match_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            count        <= '0;
            load_pending <= 1'b0;
        end else begin
            if (tick) begin
                count <= next_cnt;
            end
            if (load_stb) begin
                load_pending <= 1'b1;
            end else if (tick) begin
                load_pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rtc_csr.sv
`timescale 1ns/100ps
module rtc_csr
    import rtc_sec_pkg::*;
#(
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h0001_0002
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              alarm_hit,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  match_val,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_stb,
    output logic              raw_alarm,
    output logic              irq,
    output logic              ack_rd
);
    reg_sel_e sel;
    logic     wr;
    logic     rd;
    logic     unused_addr_lsb;

    assign sel             = reg_sel_e'(bus_addr[4:2]);
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign wr              = bus_en &  bus_we;
    assign rd              = bus_en & ~bus_we;
    assign load_stb        = wr && (sel == REG_LOAD);
    assign ack_rd          = rd && (sel == REG_ACK);
    assign irq             = irq_gate(raw_alarm, ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            match_val <= '0;
            load_val  <= '0;
            raw_alarm <= 1'b0;
        end else begin
            if (wr) begin
                case (sel)
                    REG_MATCH: match_val <= bus_wdata[CNT_W-1:0];
                    REG_LOAD:  load_val  <= bus_wdata[CNT_W-1:0];
                    REG_CTRL:  ctrl      <= ctrl_unpack(bus_wdata);
                    default:   ;
                endcase
            end
            if (alarm_hit) begin
                raw_alarm <= 1'b1;
            end else if (ack_rd) begin
                raw_alarm <= 1'b0;
            end
        end
    end

    always_comb begin
        case (sel)
            REG_COUNT: bus_rdata = DATA_W'(count);
            REG_MATCH: bus_rdata = DATA_W'(match_val);
            REG_LOAD:  bus_rdata = DATA_W'(load_val);
            REG_CTRL:  bus_rdata = ctrl_pack(ctrl);
            REG_MSTAT: bus_rdata = DATA_W'(irq);
            REG_RSTAT: bus_rdata = DATA_W'(raw_alarm);
            REG_VER:   bus_rdata = VERSION;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_sec_core.sv
`timescale 1ns/100ps
module rtc_sec_core
    import rtc_sec_pkg::*;
#(
    parameter int          CNT_W         = 32,
    parameter int unsigned TICKS_PER_SEC = 16,
    parameter logic [31:0] VERSION       = 32'h0001_0002
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    ctrl_t            ctrl;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] match_val;
    logic [CNT_W-1:0] load_val;
    logic             load_stb;
    logic             load_pending;
    logic             alarm_hit;
    logic             raw_alarm;
    logic             ack_rd;

    rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.run),
        .tick (tick)
    );

    rtc_sec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .wrap_en      (ctrl.wrap),
        .load_stb     (load_stb),
        .load_val     (load_val),
        .match_val    (match_val),
        .count        (count),
        .load_pending (load_pending),
        .alarm_hit    (alarm_hit)
    );

    rtc_csr #(.CNT_W(CNT_W), .VERSION(VERSION)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .alarm_hit (alarm_hit),
        .ctrl      (ctrl),
        .match_val (match_val),
        .load_val  (load_val),
        .load_stb  (load_stb),
        .raw_alarm (raw_alarm),
        .irq       (irq_o),
        .ack_rd    (ack_rd)
    );
endmodule

// File: rtl/rtc_sec_core_chk.sv
`timescale 1ns/100ps
module rtc_sec_core_chk
    import rtc_sec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] match_val,
    input logic [CNT_W-1:0] load_val,
    input logic             load_pending,
    input logic             raw_alarm,
    input logic             ack_rd,
    input logic             irq_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_pending && count != TOP) |=> count == $past(count) + CNT_W'(1))
        else $error("R3 step");

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && load_pending) |=> count == $past(load_val))
        else $error("R4 load");

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> $stable(count))
        else $error("R5 hold");

    p_raw_match_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_alarm) |-> count == match_val)
        else $error("R6 raw set");

    p_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mask || !raw_alarm) |-> !irq_o)
        else $error("R7 gating");

    p_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !tick) |=> !raw_alarm)
        else $error("R8 ack");

    p_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_pending && !ctrl.wrap && count == TOP) |=> count == TOP)
        else $error("R9 saturate");

    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_pending && ctrl.wrap && count == TOP) |=> count == '0)
        else $error("R9 wrap");
endmodule

bind rtc_sec_core rtc_sec_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .ctrl         (ctrl),
    .count        (count),
    .match_val    (match_val),
    .load_val     (load_val),
    .load_pending (load_pending),
    .raw_alarm    (raw_alarm),
    .ack_rd       (ack_rd),
    .irq_o        (irq_o)
);

// File: tb/sim_rtc_sec_core.sv
`timescale 1ns/100ps
module sim_rtc_sec_core;
    localparam int          TPS = 4;
    localparam logic [31:0] VER = 32'h0001_0002;
    localparam int          NV  = 14;

    // {write, byte address, data (write value or expected read value)}
    localparam logic [37:0] VEC [NV] = '{
        {1'b1, 5'h04, 32'h0000_0005},
        {1'b0, 5'h04, 32'h0000_0005},
        {1'b1, 5'h08, 32'h0000_0100},
        {1'b0, 5'h08, 32'h0000_0100},
        {1'b1, 5'h00, 32'h0000_DEAD},
        {1'b0, 5'h00, 32'h0000_0000},
        {1'b1, 5'h1C, 32'h0000_0000},
        {1'b0, 5'h1C, VER},
        {1'b1, 5'h0C, 32'hFFFF_FFF3},
        {1'b0, 5'h0C, 32'h0000_0003},
        {1'b0, 5'h10, 32'h0000_0000},
        {1'b0, 5'h14, 32'h0000_0000},
        {1'b1, 5'h0C, 32'h0000_0000},
        {1'b0, 5'h00, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rtc_sec_core #(.CNT_W(32), .TICKS_PER_SEC(TPS), .VERSION(VER)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // combinational read inside the low phase; consumes no clock edge
    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.3;
        d = bus_rdata;
        bus_en = 1'b0;
        #0.1;
    endtask

    task automatic peek_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        peek(a, d);
        chk(tag, d, exp);
    endtask

    // each of these consumes exactly one rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic ack();
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 5'h18;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek_chk("R1 count", 5'h00, 32'h0);
        peek_chk("R1 match", 5'h04, 32'h0);
        peek_chk("R1 load", 5'h08, 32'h0);
        peek_chk("R1 ctrl", 5'h0C, 32'h0);
        peek_chk("R1 gated", 5'h10, 32'h0);
        peek_chk("R1 raw", 5'h14, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2 register map walk, counter stopped; last read shows load not yet applied (R4)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][37]) begin
                wr(VEC[i][36:32], VEC[i][31:0]);
            end else begin
                peek_chk("R2 table read", VEC[i][36:32], VEC[i][31:0]);
            end
        end

        // R3/R4: run set with pending load 0x100
        wr(5'h0C, 32'h4);
        cyc(TPS - 1);
        peek_chk("R3 no update before period", 5'h00, 32'h0);
        cyc(1);
        peek_chk("R4 load applied at first update", 5'h00, 32'h100);
        cyc(TPS - 1);
        peek_chk("R3 held between updates", 5'h00, 32'h100);
        cyc(1);
        peek_chk("R3 increment", 5'h00, 32'h101);

        // R6/R7/R8 alarm round trip
        wr(5'h0C, 32'h0);
        wr(5'h04, 32'h103);
        wr(5'h0C, 32'h5);
        cyc(2 * TPS - 1);
        peek_chk("R6 raw clear before match", 5'h14, 32'h0);
        cyc(1);
        peek_chk("R6 count at match", 5'h00, 32'h103);
        peek_chk("R6 raw set at match", 5'h14, 32'h1);
        peek_chk("R7 gated set", 5'h10, 32'h1);
        chk("R7 irq high", {31'b0, irq_o}, 32'h1);
        wr(5'h0C, 32'h7);
        peek_chk("R7 mask hides gated", 5'h10, 32'h0);
        chk("R7 mask lowers irq", {31'b0, irq_o}, 32'h0);
        peek_chk("R7 raw still set under mask", 5'h14, 32'h1);
        wr(5'h0C, 32'h4);
        chk("R7 enable off lowers irq", {31'b0, irq_o}, 32'h0);
        wr(5'h0C, 32'h5);
        chk("R7 irq returns", {31'b0, irq_o}, 32'h1);
        ack();
        peek_chk("R8 raw cleared by ack read", 5'h14, 32'h0);
        chk("R8 irq low after ack", {31'b0, irq_o}, 32'h0);

        // R9 wrap
        wr(5'h0C, 32'h0);
        wr(5'h08, 32'hFFFF_FFFE);
        wr(5'h04, 32'h0);
        wr(5'h0C, 32'hC);
        cyc(TPS);
        peek_chk("R9 loaded near top", 5'h00, 32'hFFFF_FFFE);
        cyc(TPS);
        peek_chk("R9 top value", 5'h00, 32'hFFFF_FFFF);
        cyc(TPS);
        peek_chk("R9 wrap to zero", 5'h00, 32'h0);
        peek_chk("R6 alarm at wrapped zero", 5'h14, 32'h1);
        wr(5'h14, 32'h0);
        wr(5'h10, 32'h0);
        peek_chk("R2 status writes ignored", 5'h14, 32'h1);
        ack();
        peek_chk("R8 raw cleared", 5'h14, 32'h0);

        // R9 saturate
        wr(5'h0C, 32'h0);
        wr(5'h08, 32'hFFFF_FFFE);
        wr(5'h0C, 32'h4);
        cyc(TPS);
        peek_chk("R9 sat loaded", 5'h00, 32'hFFFF_FFFE);
        cyc(TPS);
        peek_chk("R9 sat top", 5'h00, 32'hFFFF_FFFF);
        cyc(TPS);
        peek_chk("R9 saturate holds top", 5'h00, 32'hFFFF_FFFF);
        peek_chk("R6 no alarm while saturated", 5'h14, 32'h0);

        // R5 hold while stopped, with pending load
        wr(5'h0C, 32'h0);
        wr(5'h08, 32'h55);
        cyc(3 * TPS);
        peek_chk("R5 count holds while stopped", 5'h00, 32'hFFFF_FFFF);
        wr(5'h0C, 32'h4);
        cyc(TPS - 1);
        peek_chk("R5 divider restarted", 5'h00, 32'hFFFF_FFFF);
        cyc(1);
        peek_chk("R5 pending load applied after run", 5'h00, 32'h55);

        summary();
        $finish;
    end
endmodule